// File: doc/BRIEF.md
# Ordered Quantum Commit Sequencer

This block keeps deterministic order among speculative quanta running on several cores at once. Every core owns one slot and runs one quantum at a time. A slot's place in the global order is its own index, measured from a rotating commit pointer. The rank of slot `i` is `(i - head) mod N_SLOTS`, and rank 0 is the oldest quantum. Quanta may finish in any order, but they retire one at a time and only from the slot the pointer names. Each commit moves the pointer forward by one, and the pointer wraps after the last slot.

Address-level conflict detection and data buffering happen outside the block, which receives their results as events. A conflict event names two slots, and the block restarts whichever of the two is younger. A forwarding event records that a younger quantum read uncommitted data from an older one. If a quantum that has handed data onward is later restarted, every quantum younger than it restarts in the same cycle. Each core may hold at most one finished quantum awaiting retirement, and `hold_o` tells the core to stall until that quantum retires or is restarted.

Top module: `qcs_sequencer`

## Requirements
- R1: A commit strobe appears only on the slot that `head_o` named before the edge, at most one per cycle. It appears in the cycle after `hold_o` of the head slot is seen high.
- R2: After reset, `head_o` is 0 and all strobes and holds are low. Each commit moves `head_o` to the next slot, wrapping from `N_SLOTS-1` to 0, and the pointer does not move in any other cycle.
- R3: A finished slot that is not at the head raises `hold_o` one cycle after its `done_i` pulse and keeps it high without committing until every older slot has committed.
- R4: A conflict event whose two slot indices differ raises `squash_o` one cycle later on the younger of the two (higher rank) and on no other slot, provided neither slot has recorded forwarding. A conflict naming the same slot twice has no effect.
- R5: A forwarding event from slot `s` to slot `d` is recorded only when `s` is older than `d`. If `s` is later restarted while such a record exists, every slot younger than `s` is restarted in the same cycle.
- R6: Restarting a slot that has no recorded outgoing forwarding restarts only that slot.
- R7: A forwarding record is dropped when its source commits or when its consumer is restarted. After that, restarting the former source no longer spreads to younger slots.
- R8: A restart clears `hold_o` of the restarted slot. When `done_i` and a restart hit the same slot in the same cycle, the restart wins and `hold_o` stays low.
- R9: The head slot is never restarted. The same slot never receives a commit strobe and a squash strobe in the same cycle, although different slots may.
- R10: A forwarding event whose source is not older than its consumer, including one naming the same slot twice, is not recorded and does not later cause spreading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | N_SLOTS | Per-slot pulse: the running quantum has finished |
| cfl_valid_i | input | 1 | A conflict event is present |
| cfl_a_i | input | IDX_W | First slot named by the conflict |
| cfl_b_i | input | IDX_W | Second slot named by the conflict |
| fwd_valid_i | input | 1 | A forwarding event is present |
| fwd_src_i | input | IDX_W | Slot that supplied uncommitted data |
| fwd_dst_i | input | IDX_W | Slot that consumed that data |
| commit_o | output | N_SLOTS | Per-slot commit strobe, one cycle |
| squash_o | output | N_SLOTS | Per-slot restart strobe, one cycle |
| hold_o | output | N_SLOTS | Per-slot: a finished quantum awaits commit |
| head_o | output | IDX_W | Slot whose quantum is oldest |

## Verification
The bench builds the block with `N_SLOTS = 4`. With four slots the commit pointer wraps completely, and a single restart can spread across two younger slots at once. Sequences of commits also change the ranks, so a forwarding source becomes the oldest slot and then the youngest. This makes it possible to show that a record dropped after its source commits does not spread a later restart, and that records with reversed ranks are refused.

// File: rtl/qcs_pkg.sv
package qcs_pkg;

    // State of one per-core slot
    typedef enum logic {
        SLOT_RUN  = 1'b0,
        SLOT_DONE = 1'b1
    } slot_state_e;

    // Why a slot restarts in a given cycle
    typedef struct packed {
        logic direct;
        logic spread;
    } squash_cause_t;

    // Distance of a slot from the commit pointer; 0 is the oldest
    function automatic int unsigned order_rank(input int unsigned slot,
                                               input int unsigned head,
                                               input int unsigned n);
        return (slot >= head) ? (slot - head) : (slot + n - head);
    endfunction

    // Commit pointer successor, wrapping at n
    function automatic int unsigned step_wrap(input int unsigned h,
                                              input int unsigned n);
        return (h + 1 >= n) ? 0 : h + 1;
    endfunction

endpackage

// File: rtl/qcs_squash_resolve.sv
module qcs_squash_resolve
    import qcs_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2
)(
    input  logic [IDX_W-1:0]   head_i,
    input  logic               cfl_valid_i,
    input  logic [IDX_W-1:0]   cfl_a_i,
    input  logic [IDX_W-1:0]   cfl_b_i,
    input  logic [N_SLOTS-1:0] fwd_out_i,
    output logic [N_SLOTS-1:0] squash_o
);

    logic [IDX_W-1:0] rank_w [N_SLOTS];
    logic [IDX_W-1:0] rank_a;
    logic [IDX_W-1:0] rank_b;
    logic [IDX_W-1:0] victim;
    logic             evt_ok;
    logic [N_SLOTS-1:0] direct_w;
    squash_cause_t      cause [N_SLOTS];

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_rank
        assign rank_w[i] = IDX_W'(order_rank(i, 32'(head_i), N_SLOTS));
    end

    always_comb begin
        rank_a = IDX_W'(order_rank(32'(cfl_a_i), 32'(head_i), N_SLOTS));
        rank_b = IDX_W'(order_rank(32'(cfl_b_i), 32'(head_i), N_SLOTS));
        evt_ok = cfl_valid_i && (cfl_a_i != cfl_b_i)
                 && (32'(cfl_a_i) < N_SLOTS) && (32'(cfl_b_i) < N_SLOTS);
        // The younger quantum of the pair always loses
        victim = (rank_a > rank_b) ? cfl_a_i : cfl_b_i;
    end

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_direct
        assign direct_w[i] = evt_ok && (victim == IDX_W'(i));
    end

    // A restarted quantum that fed data onward drags every younger one along
    always_comb begin
        for (int j = 0; j < N_SLOTS; j++) begin
            cause[j].direct = direct_w[j];
            cause[j].spread = 1'b0;
            for (int i = 0; i < N_SLOTS; i++) begin
                if (direct_w[i] && fwd_out_i[i] && (rank_w[i] < rank_w[j]))
                    cause[j].spread = 1'b1;
            end
        end
    end

    for (genvar j = 0; j < N_SLOTS; j++) begin : g_out
        assign squash_o[j] = cause[j].direct | cause[j].spread;
    end

endmodule

// File: rtl/qcs_fwd_tracker.sv
module qcs_fwd_tracker
    import qcs_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               fwd_valid_i,
    input  logic [IDX_W-1:0]   fwd_src_i,
    input  logic [IDX_W-1:0]   fwd_dst_i,
    input  logic [IDX_W-1:0]   head_i,
    input  logic [N_SLOTS-1:0] squash_i,
    input  logic [N_SLOTS-1:0] commit_i,
    output logic [N_SLOTS-1:0] fwd_out_o
);

    // link_q[s][d]: slot d consumed uncommitted data of slot s
    logic [N_SLOTS-1:0][N_SLOTS-1:0] link_q;
    logic [IDX_W-1:0] rank_w [N_SLOTS];
    logic [IDX_W-1:0] rank_src;
    logic [IDX_W-1:0] rank_dst;
    logic             in_range;
    logic             take;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_rank
        assign rank_w[i] = IDX_W'(order_rank(i, 32'(head_i), N_SLOTS));
    end

    always_comb begin
        rank_src = IDX_W'(order_rank(32'(fwd_src_i), 32'(head_i), N_SLOTS));
        rank_dst = IDX_W'(order_rank(32'(fwd_dst_i), 32'(head_i), N_SLOTS));
        in_range = (32'(fwd_src_i) < N_SLOTS) && (32'(fwd_dst_i) < N_SLOTS);
        take     = 1'b0;
        if (fwd_valid_i && in_range && (rank_src < rank_dst)) begin
            take = !squash_i[fwd_src_i] && !squash_i[fwd_dst_i]
                   && !commit_i[fwd_src_i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            link_q <= '0;
        end else begin
            for (int s = 0; s < N_SLOTS; s++) begin
                for (int d = 0; d < N_SLOTS; d++) begin
                    if (squash_i[s] || squash_i[d] || commit_i[s])
                        link_q[s][d] <= 1'b0;
                    else if (take && (fwd_src_i == IDX_W'(s))
                                  && (fwd_dst_i == IDX_W'(d)))
                        link_q[s][d] <= 1'b1;
                end
            end
        end
    end

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_row
        assign fwd_out_o[s] = |link_q[s];
        for (genvar d = 0; d < N_SLOTS; d++) begin : g_col
            AST_LINK_ORDERED: assert property (@(posedge clk) disable iff (rst)
                link_q[s][d] |-> (rank_w[s] < rank_w[d])); // R5
        end
    end

endmodule

// File: rtl/qcs_slot_ctrl.sv
module qcs_slot_ctrl
    import qcs_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int IDX_W   = 2
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SLOTS-1:0] done_i,
    input  logic [N_SLOTS-1:0] squash_i,
    output logic [N_SLOTS-1:0] commit_now_o,
    output logic [N_SLOTS-1:0] hold_o,
    output logic [N_SLOTS-1:0] commit_o,
    output logic [N_SLOTS-1:0] squash_o,
    output logic [IDX_W-1:0]   head_o
);

    logic [IDX_W-1:0] head_q;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        slot_state_e st_q;

        // Restart beats retirement and beats a fresh finish
        assign commit_now_o[i] = (head_q == IDX_W'(i)) && (st_q == SLOT_DONE)
                                 && !squash_i[i];
        assign hold_o[i]       = (st_q == SLOT_DONE);

        always_ff @(posedge clk) begin
            if (rst)
                st_q <= SLOT_RUN;
            else if (squash_i[i] || commit_now_o[i])
                st_q <= SLOT_RUN;
            else if (done_i[i])
                st_q <= SLOT_DONE;
        end

        AST_RESTART_DROPS_HOLD: assert property (@(posedge clk) disable iff (rst)
            squash_o[i] |-> !hold_o[i]); // R8
        AST_COMMIT_AFTER_FINISH: assert property (@(posedge clk) disable iff (rst)
            commit_o[i] |-> $past(hold_o[i])); // R3
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q   <= '0;
            commit_o <= '0;
            squash_o <= '0;
        end else begin
            if (|commit_now_o)
                head_q <= IDX_W'(step_wrap(32'(head_q), N_SLOTS));
            commit_o <= commit_now_o;
            squash_o <= squash_i;
        end
    end

    assign head_o = head_q;

    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(commit_o)); // R1
    AST_COMMIT_AT_HEAD: assert property (@(posedge clk) disable iff (rst)
        (|commit_o) |-> (commit_o == (N_SLOTS'(1) << $past(head_q)))); // R1
    AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (|commit_o) |-> (head_q == IDX_W'(step_wrap(32'($past(head_q)), N_SLOTS)))); // R2
    AST_HEAD_STILL: assert property (@(posedge clk) disable iff (rst)
        !(|commit_o) |-> $stable(head_q)); // R2

endmodule

// File: rtl/qcs_sequencer.sv
module qcs_sequencer
    import qcs_pkg::*;
#(
    parameter  int N_SLOTS = 4,
    localparam int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
)(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SLOTS-1:0] done_i,
    input  logic               cfl_valid_i,
    input  logic [IDX_W-1:0]   cfl_a_i,
    input  logic [IDX_W-1:0]   cfl_b_i,
    input  logic               fwd_valid_i,
    input  logic [IDX_W-1:0]   fwd_src_i,
    input  logic [IDX_W-1:0]   fwd_dst_i,
    output logic [N_SLOTS-1:0] commit_o,
    output logic [N_SLOTS-1:0] squash_o,
    output logic [N_SLOTS-1:0] hold_o,
    output logic [IDX_W-1:0]   head_o
);

    logic [N_SLOTS-1:0] squash_w;
    logic [N_SLOTS-1:0] commit_now_w;
    logic [N_SLOTS-1:0] fwd_out_w;
    logic [IDX_W-1:0]   head_w;

    qcs_squash_resolve #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_resolve (
        .head_i      (head_w),
        .cfl_valid_i (cfl_valid_i),
        .cfl_a_i     (cfl_a_i),
        .cfl_b_i     (cfl_b_i),
        .fwd_out_i   (fwd_out_w),
        .squash_o    (squash_w)
    );

    qcs_fwd_tracker #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_fwd (
        .clk         (clk),
        .rst         (rst),
        .fwd_valid_i (fwd_valid_i),
        .fwd_src_i   (fwd_src_i),
        .fwd_dst_i   (fwd_dst_i),
        .head_i      (head_w),
        .squash_i    (squash_w),
        .commit_i    (commit_now_w),
        .fwd_out_o   (fwd_out_w)
    );

    qcs_slot_ctrl #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_slots (
        .clk          (clk),
        .rst          (rst),
        .done_i       (done_i),
        .squash_i     (squash_w),
        .commit_now_o (commit_now_w),
        .hold_o       (hold_o),
        .commit_o     (commit_o),
        .squash_o     (squash_o),
        .head_o       (head_w)
    );

    assign head_o = head_w;

    AST_HEAD_NEVER_RESTARTED: assert property (@(posedge clk) disable iff (rst)
        !squash_w[head_w]); // R9
    AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (commit_o & squash_o) == '0); // R9

endmodule

// File: tb/qcs_sequencer_bench.sv
module qcs_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int IW = 2;

    typedef struct packed {
        logic [NS-1:0] c;
        logic [NS-1:0] s;
        logic [NS-1:0] h;
        logic [IW-1:0] hd;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] done_i = '0;
    logic          cfl_valid_i = 1'b0;
    logic [IW-1:0] cfl_a_i = '0;
    logic [IW-1:0] cfl_b_i = '0;
    logic          fwd_valid_i = 1'b0;
    logic [IW-1:0] fwd_src_i = '0;
    logic [IW-1:0] fwd_dst_i = '0;
    logic [NS-1:0] commit_o;
    logic [NS-1:0] squash_o;
    logic [NS-1:0] hold_o;
    logic [IW-1:0] head_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    exp_t  exp_q [$];
    string tag_q [$];

    qcs_sequencer #(.N_SLOTS(NS)) u_qcs_sequencer (
        .clk(clk), .rst(rst), .done_i(done_i),
        .cfl_valid_i(cfl_valid_i), .cfl_a_i(cfl_a_i), .cfl_b_i(cfl_b_i),
        .fwd_valid_i(fwd_valid_i), .fwd_src_i(fwd_src_i), .fwd_dst_i(fwd_dst_i),
        .commit_o(commit_o), .squash_o(squash_o), .hold_o(hold_o), .head_o(head_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: apply one cycle of stimulus and queue what must follow the edge
    task automatic step(input logic [NS-1:0] dn,
                        input logic cv, input int ca, input int cb,
                        input logic fv, input int fs, input int fd,
                        input logic [NS-1:0] ec, input logic [NS-1:0] es,
                        input logic [NS-1:0] eh, input int ehd,
                        input string tag);
        @(negedge clk);
        done_i      = dn;
        cfl_valid_i = cv;
        cfl_a_i     = IW'(ca);
        cfl_b_i     = IW'(cb);
        fwd_valid_i = fv;
        fwd_src_i   = IW'(fs);
        fwd_dst_i   = IW'(fd);
        exp_q.push_back('{c: ec, s: es, h: eh, hd: IW'(ehd)});
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [NS-1:0] ec, input logic [NS-1:0] eh,
                        input int ehd, input string tag);
        step('0, 0, 0, 0, 0, 0, 0, ec, '0, eh, ehd, tag);
    endtask

    task automatic fin(input logic [NS-1:0] dn, input logic [NS-1:0] eh,
                       input int ehd, input string tag);
        step(dn, 0, 0, 0, 0, 0, 0, '0, '0, eh, ehd, tag);
    endtask

    task automatic clash(input int a, input int b, input logic [NS-1:0] es,
                         input int ehd, input string tag);
        step('0, 1, a, b, 0, 0, 0, '0, es, '0, ehd, tag);
    endtask

    task automatic feed(input int s, input int d, input int ehd, input string tag);
        step('0, 0, 0, 0, 1, s, d, '0, '0, '0, ehd, tag);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Monitor: compare outputs a quarter period after each rising edge
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                total++;
                if (commit_o !== e.c || squash_o !== e.s
                    || hold_o !== e.h || head_o !== e.hd) begin
                    bad++;
                    $display("FAIL %s: commit=%b/%b squash=%b/%b hold=%b/%b head=%0d/%0d (actual/expected)",
                             t, commit_o, e.c, squash_o, e.s, hold_o, e.h, head_o, e.hd);
                end
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end (actual hung, expected done)");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        idle('0, '0, 0, "R2 reset state");
        // In-order retirement with an early finisher
        fin(4'b0100, 4'b0100, 0, "R3 younger finish raises hold");
        idle('0, 4'b0100, 0, "R3 younger waits for head");
        fin(4'b0001, 4'b0101, 0, "R1 head finish raises hold");
        idle(4'b0001, 4'b0100, 1, "R1 head commits, R2 pointer to 1");
        idle('0, 4'b0100, 1, "R3 slot2 still waits behind slot1");
        fin(4'b0010, 4'b0110, 1, "R1 slot1 finish");
        idle(4'b0010, 4'b0100, 2, "R1 slot1 commits");
        idle(4'b0100, '0, 3, "R3 waiting slot2 commits in turn");
        fin(4'b1000, 4'b1000, 3, "R1 slot3 finish");
        idle(4'b1000, '0, 0, "R2 pointer wraps to 0");
        // Conflicts, head = 0
        clash(2, 1, 4'b0100, 0, "R4 younger of 2,1 restarts");
        clash(0, 3, 4'b1000, 0, "R4 younger of 0,3 restarts");
        clash(1, 1, '0, 0, "R4 same-slot conflict ignored");
        step(4'b0100, 1, 1, 2, 0, 0, 0, '0, 4'b0100, '0, 0, "R8 restart beats finish");
        fin(4'b1000, 4'b1000, 0, "R8 slot3 finish");
        clash(3, 2, 4'b1000, 0, "R8 restart clears hold");
        fin(4'b0001, 4'b0001, 0, "R9 head finish");
        step('0, 1, 0, 2, 0, 0, 0, 4'b0001, 4'b0100, '0, 1, "R9 head commits while slot2 restarts");
        // Forwarding, head = 1
        feed(2, 3, 1, "R5 record 2->3");
        clash(2, 1, 4'b1101, 1, "R5 restart of source spreads to younger");
        clash(1, 2, 4'b0100, 1, "R6 no record, only slot2");
        feed(3, 2, 1, "R10 reversed forward refused");
        clash(1, 3, 4'b1000, 1, "R10 slot3 restart does not spread");
        feed(2, 2, 1, "R10 self forward refused");
        clash(1, 2, 4'b0100, 1, "R10 slot2 restart does not spread");
        feed(2, 3, 1, "R7 record 2->3 again");
        clash(2, 3, 4'b1000, 1, "R7 consumer restarted");
        clash(1, 2, 4'b0100, 1, "R7 record dropped with consumer");
        feed(2, 0, 1, "R7 record 2->0");
        fin(4'b0010, 4'b0010, 1, "R7 slot1 finish");
        idle(4'b0010, '0, 2, "R7 slot1 commits");
        fin(4'b0100, 4'b0100, 2, "R7 source finish");
        idle(4'b0100, '0, 3, "R7 source commits");
        fin(4'b1000, 4'b1000, 3, "R7 slot3 finish");
        idle(4'b1000, '0, 0, "R2 pointer wraps again");
        clash(1, 2, 4'b0100, 0, "R7 record dropped with source commit");
        idle('0, '0, 0, "R9 quiet after events");

        repeat (3) @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R1: %0d expectations left (actual) vs 0 (expected)", exp_q.size());
        end
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule